// File: doc/BRIEF.md
# Usage-Bit Replacement Selector

This block holds the replacement state for a set-associative cache. Each way of each set carries a single usage bit. The bit is raised whenever that way is touched, both on a hit and on a fill. The block picks the next way to evict from those bits alone. It holds no tags and no data, and it does not decide hit or miss. The surrounding cache tells it which set and way was accessed. It asks which way of a given set should be replaced.

A set whose ways have all been used recently would leave nothing to choose from. To prevent this, any update that would raise the last clear bit of a set wipes that whole set to zero instead. The victim is the lowest-numbered way whose bit is clear. This gives a cheap approximation of least-recently-used order. It needs one flip-flop per way and no per-way counters.

The query side is purely combinational. A victim can be read in the same cycle as the fill that will use it. An access to the same set in that cycle takes effect only at the next clock edge.

Top module: `mru_bit_replacer`

## Requirements
- R1: After reset, every usage bit of every set is 0, so the victim reported for any set is way 0.
- R2: A cycle with `acc_en` high raises the usage bit of way `acc_way` in set `acc_set` at the next clock edge, unless R3 applies. Hits and fills are treated the same way. Bit i of `qry_bits` is the usage bit of way i.
- R3: When an access would leave every usage bit of the addressed set at 1, all bits of that set read 0 after the edge, including the bit of the way just accessed.
- R4: `victim_way` is the lowest way index, counting from 0, whose usage bit in set `qry_set` is 0.
- R5: An access changes only the addressed set; the bits of every other set are unchanged.
- R6: `victim_way` and `qry_bits` are combinational from the stored bits of `qry_set`. An access and a query to the same set in one cycle return the state from before that access.
- R7: In a cycle with `acc_en` low, no usage bit changes, whatever the values on `acc_set` and `acc_way`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe: a hit or a fill into a way |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way index of the access |
| qry_set | input | SET_W | Set index of the victim query |
| victim_way | output | WAY_W | Lowest way of `qry_set` whose usage bit is clear |
| qry_bits | output | WAYS | Usage bits of `qry_set`, bit i for way i |

## Verification
The assertions check the following on every cycle:
- the victim always points at a clear bit, with every lower way set;
- the queried set is never left fully set;
- an accepted access raises its bit unless it saturated the set, in which case the set reads all zero;
- sets that are not addressed, and all sets when the strobe is low, hold their bits.

Only the bench's scenarios can show the rest:
- the reset state across all sets;
- that a same-cycle query sees the state from before the access;
- that long mixed sequences of hits and fills give the victim order a reference model predicts.

// File: rtl/mru_repl_pkg.sv
package mru_repl_pkg;

  localparam int unsigned MAX_WAYS = 64;

  function automatic logic [MAX_WAYS-1:0] mark_way(input logic [MAX_WAYS-1:0] bits,
                                                   input int unsigned way);
    logic [MAX_WAYS-1:0] r;
    r = bits;
    r[way] = 1'b1;
    return r;
  endfunction

  function automatic logic all_marked(input logic [MAX_WAYS-1:0] bits,
                                      input int unsigned n);
    for (int unsigned i = 0; i < n; i++) begin
      if (!bits[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int unsigned first_clear(input logic [MAX_WAYS-1:0] bits,
                                              input int unsigned n);
    for (int unsigned i = 0; i < n; i++) begin
      if (!bits[i]) return i;
    end
    return 0;
  endfunction

endpackage

// File: rtl/mru_usage_row.sv
module mru_usage_row
  import mru_repl_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [WAY_W-1:0] way,
  output logic [WAYS-1:0]  bits,
  output logic             sat
);
  logic [WAYS-1:0] bits_q;
  logic [WAYS-1:0] marked;

  always_comb begin
    marked = WAYS'(mark_way(MAX_WAYS'(bits_q), int'(way)));
    sat    = hit && all_marked(MAX_WAYS'(marked), WAYS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   bits_q <= '0;
    else if (sat) bits_q <= '0;
    else if (hit) bits_q <= marked;
  end

  assign bits = bits_q;
endmodule

// File: rtl/mru_victim_pick.sv
module mru_victim_pick
  import mru_repl_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0]  bits,
  output logic [WAY_W-1:0] way
);
  always_comb way = WAY_W'(first_clear(MAX_WAYS'(bits), WAYS));
endmodule

// File: rtl/mru_bit_replacer.sv
module mru_bit_replacer #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [SET_W-1:0] qry_set,
  output logic [WAY_W-1:0] victim_way,
  output logic [WAYS-1:0]  qry_bits
);
  logic [SETS-1:0][WAYS-1:0] usage_all;
  logic [SETS-1:0]           sat_vec;
  logic [SETS-1:0]           row_hit;
  logic                      sat_fire;

  for (genvar s = 0; s < SETS; s++) begin : g_row
    assign row_hit[s] = acc_en && (acc_set == SET_W'(s));
    mru_usage_row #(.WAYS(WAYS), .WAY_W(WAY_W)) u_row (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (row_hit[s]),
      .way  (acc_way),
      .bits (usage_all[s]),
      .sat  (sat_vec[s])
    );
  end

  assign sat_fire = |sat_vec;

  always_comb begin
    qry_bits = '0;
    if (int'(qry_set) < SETS) qry_bits = usage_all[qry_set];
  end

  mru_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .bits(qry_bits),
    .way (victim_way)
  );
endmodule

// File: rtl/mru_repl_checker.sv
module mru_repl_checker #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_en,
  input logic [SET_W-1:0]          acc_set,
  input logic [WAY_W-1:0]          acc_way,
  input logic [WAY_W-1:0]          victim_way,
  input logic [WAYS-1:0]           qry_bits,
  input logic [SETS-1:0][WAYS-1:0] usage_all,
  input logic                      sat_fire
);
  logic             pend_mark, pend_clear;
  logic [SET_W-1:0] pend_set;
  logic [WAY_W-1:0] pend_way;
  logic [WAYS-1:0]  low_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mark  <= 1'b0;
      pend_clear <= 1'b0;
      pend_set   <= '0;
      pend_way   <= '0;
    end else begin
      pend_mark  <= acc_en && !sat_fire;
      pend_clear <= acc_en && sat_fire;
      pend_set   <= acc_set;
      pend_way   <= acc_way;
    end
  end

  always_comb low_mask = (WAYS'(1) << victim_way) - WAYS'(1);

  AST_MARK_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) pend_mark |-> usage_all[pend_set][pend_way]); // R2
  AST_CLEAR_ON_SAT: assert property (@(posedge clk) disable iff (!rst_n) pend_clear |-> (usage_all[pend_set] == '0)); // R3
  AST_VICTIM_IS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !qry_bits[victim_way]); // R4
  AST_VICTIM_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) (qry_bits & low_mask) == low_mask); // R4
  AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n) qry_bits != '1); // R3

  for (genvar s = 0; s < SETS; s++) begin : g_set
    AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !(acc_en && acc_set == SET_W'(s)) |=> $stable(usage_all[s])); // R5 R7
  end
endmodule

bind mru_bit_replacer mru_repl_checker #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_set   (acc_set),
  .acc_way   (acc_way),
  .victim_way(victim_way),
  .qry_bits  (qry_bits),
  .usage_all (usage_all),
  .sat_fire  (sat_fire)
);

// File: tb/mru_bit_replacer_test.sv
`timescale 1ns/1ps
module mru_bit_replacer_test;
  localparam int unsigned SETS = 16;
  localparam int unsigned WAYS = 4;
  localparam int unsigned SET_W = 4;
  localparam int unsigned WAY_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0;
  logic [SET_W-1:0] acc_set = '0;
  logic [WAY_W-1:0] acc_way = '0;
  logic [SET_W-1:0] qry_set = '0;
  logic [WAY_W-1:0] victim_way;
  logic [WAYS-1:0]  qry_bits;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [WAYS-1:0] model [SETS];

  always #2.5 clk = ~clk;

  mru_bit_replacer #(.SETS(SETS), .WAYS(WAYS)) uut (.*);

  function automatic logic [WAY_W-1:0] exp_victim(input logic [WAYS-1:0] b);
    for (int i = WAYS - 1; i >= 0; i--) if (b[i] == 1'b0) exp_victim = WAY_W'(i);
    if (b == '1) exp_victim = '0;
  endfunction

  function automatic logic [WAYS-1:0] exp_after(input logic [WAYS-1:0] b, input int w);
    logic [WAYS-1:0] n;
    n = b | (WAYS'(1) << w);
    return (n == '1) ? '0 : n;
  endfunction

  task automatic check(input string tag, input int qs);
    checks++;
    if (qry_bits !== model[qs] || victim_way !== exp_victim(model[qs])) begin
      errors++;
      $display("FAIL %s set=%0d bits=%b victim=%0d expected bits=%b victim=%0d",
               tag, qs, qry_bits, victim_way, model[qs], exp_victim(model[qs]));
    end
  endtask

  task automatic step(input string tag, input bit en, input int s, input int w, input int qs);
    @(negedge clk);
    acc_en = en; acc_set = SET_W'(s); acc_way = WAY_W'(w); qry_set = SET_W'(qs);
    #1;
    check(tag, qs);
    @(posedge clk);
    if (en) model[s] = exp_after(model[s], w);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int s = 0; s < SETS; s++) model[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int s = 0; s < SETS; s++) step("R1 reset state", 0, 0, 0, s);
    step("R6 same-cycle pre-update", 1, 5, 1, 5);
    step("R2 bit raised", 1, 5, 0, 5);
    step("R2 fill sets bit", 1, 5, 3, 5);
    step("R4 lowest clear way", 0, 5, 2, 5);
    step("R7 strobe low ignored", 0, 5, 2, 5);
    step("R3 saturating access", 1, 5, 2, 6);
    step("R3 set cleared", 0, 0, 0, 5);
    step("R5 other set untouched", 1, 9, 0, 6);
    step("R5 addressed set", 0, 0, 0, 9);
    for (int w = 0; w < WAYS; w++) step("R3 walk", 1, 12, w, 12);
    step("R3 walk cleared", 0, 0, 0, 12);
    for (int i = 0; i < 4000; i++) begin
      int s, w, q;
      s = int'($urandom_range(SETS - 1));
      w = int'($urandom_range(WAYS - 1));
      q = ($urandom_range(3) == 0) ? s : int'($urandom_range(SETS - 1));
      step("R2 R3 R4 R5 R6 R7 random", ($urandom_range(4) != 0), s, w, q);
    end
    for (int s = 0; s < SETS; s++) step("R4 R5 final sweep", 0, 0, 0, s);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule